// File: doc/BRIEF.md
# Symmetric Filter Kernel Expander

This block holds the coefficient kernel used by a polyphase image scaler. The kernel has linear phase: its 32 coefficients are symmetric around the middle, so software only provides the first half. That half arrives as six packed 32-bit words, each carrying three signed 9-bit coefficients. When the last of the six words is accepted, the block rebuilds an eleven-word kernel store. The first six words are copied straight from the load. Each of the remaining five is a copy of one of the first five, taken in mirror order.

The scaler fetches single coefficients through a lookup stream. It presents a coefficient index from 0 to 31. One cycle after the request is accepted, the block returns that coefficient, sign-extended to 16 bits.

- **Coefficients 0 to 16** run upward through the store.
- **The sixth loaded word** carries coefficient 15 in two slots, followed by a pad slot.
- **Coefficients 17 to 31** run downward through the mirrored words, with the slot order reversed inside each word.

Back-pressure works as follows:

- The load stream never stalls.
- The lookup response is held stable for as long as its ready input is low.
- While a response is held, no new request is accepted.

Out of reset, the store holds a default kernel.

Top module: `sym_kernel_expander`

## Requirements
- R1: After reset, the store holds the default half kernel 0, -2, -6, -8, -10, -8, -3, 2, 18, 50, 82, 119, 155, 187, 213, 227. Index 16 returns the same value as index 15. No response is pending, and both `ld_ready` and `req_ready` are high.
- R2: A loaded word places its coefficient for slot s in bits [9s+8:9s], for s = 0, 1, 2. Bits 31 to 27 of a loaded word have no effect on any lookup.
- R3: An index k from 0 to 16 returns slot k mod 3 of loaded word k div 3. Index 16 is therefore slot 1 of the sixth word.
- R4: An index k from 17 to 31 returns slot 2 - ((k-17) mod 3) of loaded word 4 - ((k-17) div 3). For a kernel whose sixth word repeats coefficient 15, this gives c[k] = c[31-k] for every k.
- R5: The pad slot (bits 26:18 of the sixth loaded word) is never returned for any index.
- R6: The 9-bit coefficient is sign-extended to 16 bits. Bits 15 to 9 of `rsp_coef` all equal bit 8.
- R7: A request accepted on one clock edge gives `rsp_valid` high after that edge, with the coefficient.
  - A response with `rsp_ready` low holds its value and stays valid.
  - `req_ready` equals `!rsp_valid || rsp_ready`.
  - A response consumed with no new request accepted drops `rsp_valid`.
- R8: Loaded words are counted modulo six. The sixth accepted word re-expands the whole store on the edge that accepts it. Any lookup accepted up to and including that edge returns the previous kernel.
- R9: `ld_ready` is always high. Every cycle with `ld_valid` high accepts one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Packed half-kernel word valid |
| ld_ready | output | 1 | Load stream ready (always high) |
| ld_data | input | 32 | Packed word: three 9-bit coefficients |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request ready |
| req_idx | input | 5 | Coefficient index 0 to 31 |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Lookup response ready |
| rsp_coef | output | 16 | Sign-extended coefficient |

## Verification
The hardest case to reach is a lookup accepted on the very edge that accepts the sixth load word. At that edge the store is still being rewritten, and the answer must come from the old kernel. The bench drives `ld_valid` for the sixth word and `req_valid` in the same cycle, then checks the response against the previous kernel. A second hard case is a response stalled with `rsp_ready` low while a new request waits. The bench holds the stall for several cycles, then releases it so that the pending response and the next request both transfer on one edge.

// File: rtl/ske_pkg.sv
`timescale 1ns/1ps
package ske_pkg;
  localparam int SKE_COEF_W = 9;
  localparam int SKE_SLOTS  = 3;
  localparam int SKE_HALF   = 6;
  localparam int SKE_PACK_W = SKE_COEF_W * SKE_SLOTS;

  // Default half kernel, coefficient n for n in 0..15.
  function automatic logic [SKE_COEF_W-1:0] dflt_coef(input int n);
    int v;
    case (n)
      0: v = 0;     1: v = -2;    2: v = -6;    3: v = -8;
      4: v = -10;   5: v = -8;    6: v = -3;    7: v = 2;
      8: v = 18;    9: v = 50;    10: v = 82;   11: v = 119;
      12: v = 155;  13: v = 187;  14: v = 213;  15: v = 227;
      default: v = 0;
    endcase
    return v[SKE_COEF_W-1:0];
  endfunction

  // Packed default half-kernel word w (0..SKE_HALF-1); last word repeats c15 then pad.
  function automatic logic [SKE_PACK_W-1:0] dflt_word(input int w);
    if (w == SKE_HALF - 1)
      return {{SKE_COEF_W{1'b0}}, dflt_coef(15), dflt_coef(15)};
    return {dflt_coef(3*w+2), dflt_coef(3*w+1), dflt_coef(3*w)};
  endfunction
endpackage

// File: rtl/ske_load_stage.sv
`timescale 1ns/1ps
module ske_load_stage #(
  parameter int HALF_WORDS = 6,
  parameter int PACK_W     = 27,
  localparam int CNT_W     = $clog2(HALF_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_fire,
  input  logic [PACK_W-1:0]            ld_word,
  output logic                         commit,
  output logic [HALF_WORDS*PACK_W-1:0] half_flat
);
  logic [CNT_W-1:0]  cnt_q;
  logic [PACK_W-1:0] shadow_q [HALF_WORDS-1];

  assign commit = ld_fire && (cnt_q == CNT_W'(HALF_WORDS-1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (ld_fire)
      cnt_q <= commit ? '0 : cnt_q + 1'b1;
  end

  for (genvar i = 0; i < HALF_WORDS-1; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rst_n)
        shadow_q[i] <= '0;
      else if (ld_fire && cnt_q == CNT_W'(i))
        shadow_q[i] <= ld_word;
    end
    assign half_flat[i*PACK_W +: PACK_W] = shadow_q[i];
  end
  // The final word goes straight from the stream into the store.
  assign half_flat[(HALF_WORDS-1)*PACK_W +: PACK_W] = ld_word;
endmodule

// File: rtl/ske_mirror_mem.sv
`timescale 1ns/1ps
module ske_mirror_mem #(
  parameter int HALF_WORDS = 6,
  parameter int PACK_W     = 27,
  localparam int FULL_WORDS = 2*HALF_WORDS - 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [HALF_WORDS*PACK_W-1:0] half_flat,
  output logic [FULL_WORDS*PACK_W-1:0] mem_flat
);
  for (genvar i = 0; i < FULL_WORDS; i++) begin : g_word
    // Upper words are mirror copies of the lower ones.
    localparam int SRC = (i < HALF_WORDS) ? i : FULL_WORDS - 1 - i;
    logic [PACK_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= ske_pkg::dflt_word(SRC);
      else if (commit)
        word_q <= half_flat[SRC*PACK_W +: PACK_W];
    end
    assign mem_flat[i*PACK_W +: PACK_W] = word_q;
  end
endmodule

// File: rtl/ske_index_map.sv
`timescale 1ns/1ps
module ske_index_map #(
  parameter int HALF_WORDS = 6,
  parameter int IDX_W      = 5,
  parameter int WIDX_W     = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WIDX_W-1:0] word,
  output logic [1:0]        slot
);
  localparam int UP_CNT = 3*HALF_WORDS - 1;
  int k_i, j_i, w_i, s_i;

  always_comb begin
    k_i = int'(idx);
    j_i = 0;
    if (k_i < UP_CNT) begin
      w_i = k_i / 3;
      s_i = k_i % 3;
    end else begin
      j_i = k_i - UP_CNT;
      w_i = HALF_WORDS + j_i / 3;
      s_i = 2 - (j_i % 3);
    end
    word = w_i[WIDX_W-1:0];
    slot = s_i[1:0];
  end
endmodule

// File: rtl/ske_resp_stage.sv
`timescale 1ns/1ps
module ske_resp_stage #(
  parameter int FULL_WORDS = 11,
  parameter int COEF_W     = 9,
  parameter int OUT_W      = 16,
  parameter int WIDX_W     = 4,
  localparam int PACK_W    = 3*COEF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [FULL_WORDS*PACK_W-1:0] mem_flat,
  input  logic [WIDX_W-1:0]            word,
  input  logic [1:0]                   slot,
  input  logic                         req_valid,
  output logic                         req_ready,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [OUT_W-1:0]             rsp_coef
);
  logic [PACK_W-1:0] sel_word;
  logic [COEF_W-1:0] sel_coef;
  logic              req_fire;

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < FULL_WORDS; w++)
      if (word == WIDX_W'(w)) sel_word = mem_flat[w*PACK_W +: PACK_W];
    case (slot)
      2'd0:    sel_coef = sel_word[0 +: COEF_W];
      2'd1:    sel_coef = sel_word[COEF_W +: COEF_W];
      default: sel_coef = sel_word[2*COEF_W +: COEF_W];
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_coef  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_coef  <= {{(OUT_W-COEF_W){sel_coef[COEF_W-1]}}, sel_coef};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sym_kernel_expander.sv
`timescale 1ns/1ps
module sym_kernel_expander #(
  parameter int WORD_W     = 32,
  parameter int COEF_W     = ske_pkg::SKE_COEF_W,
  parameter int HALF_WORDS = ske_pkg::SKE_HALF,
  parameter int OUT_W      = 16,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [OUT_W-1:0]  rsp_coef
);
  localparam int PACK_W     = 3*COEF_W;
  localparam int FULL_WORDS = 2*HALF_WORDS - 1;
  localparam int WIDX_W     = $clog2(FULL_WORDS);

  logic                         commit;
  logic [HALF_WORDS*PACK_W-1:0] half_flat;
  logic [FULL_WORDS*PACK_W-1:0] mem_flat;
  logic [WIDX_W-1:0]            map_word;
  logic [1:0]                   map_slot;
  logic                         spare_bits_unused;

  assign ld_ready          = 1'b1;
  assign spare_bits_unused = ^ld_data[WORD_W-1:PACK_W];

  ske_load_stage #(.HALF_WORDS(HALF_WORDS), .PACK_W(PACK_W)) u_load (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_valid && ld_ready),
    .ld_word(ld_data[PACK_W-1:0]), .commit(commit), .half_flat(half_flat)
  );

  ske_mirror_mem #(.HALF_WORDS(HALF_WORDS), .PACK_W(PACK_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .half_flat(half_flat), .mem_flat(mem_flat)
  );

  ske_index_map #(.HALF_WORDS(HALF_WORDS), .IDX_W(IDX_W), .WIDX_W(WIDX_W)) u_map (
    .idx(req_idx), .word(map_word), .slot(map_slot)
  );

  ske_resp_stage #(.FULL_WORDS(FULL_WORDS), .COEF_W(COEF_W), .OUT_W(OUT_W),
                   .WIDX_W(WIDX_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .mem_flat(mem_flat), .word(map_word),
    .slot(map_slot), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_coef(rsp_coef)
  );
endmodule

// File: rtl/ske_checker.sv
`timescale 1ns/1ps
module ske_checker #(
  parameter int COEF_W = 9,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [OUT_W-1:0] rsp_coef
);
  logic [OUT_W-COEF_W:0] hi;
  assign hi = rsp_coef[OUT_W-1:COEF_W-1];

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_coef)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);

  p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((&hi) || !(|hi)));
endmodule

bind sym_kernel_expander ske_checker #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_coef(rsp_coef)
);

// File: tb/sym_kernel_expander_tb_top.sv
`timescale 1ns/1ps
module sym_kernel_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [31:0] ld_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_idx = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_coef;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sym_kernel_expander dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_coef(rsp_coef)
  );

  // Stimulus table: default half kernel values.
  localparam int DFLT [16] = '{0, -2, -6, -8, -10, -8, -3, 2, 18, 50, 82, 119,
                               155, 187, 213, 227};
  // New kernel: 18 slot values, word w slot s at 3*w+s; entry 17 is the pad.
  localparam int NEWK [18] = '{-256, 255, -1, 1, -100, 100, 7, -7, 64,
                               -64, 33, -33, 200, -200, 5, -5, 120, 170};

  function automatic int exp_default(input int k);
    if (k < 16) return DFLT[k];
    if (k == 16) return DFLT[15];
    return DFLT[31-k];
  endfunction

  function automatic int exp_new(input int k);
    int j;
    if (k < 17) return NEWK[k];
    j = k - 17;
    return NEWK[3*(4 - j/3) + (2 - j%3)];
  endfunction

  function automatic logic [31:0] new_word(input int w);
    logic [8:0] s0, s1, s2;
    s0 = 9'(NEWK[3*w]); s1 = 9'(NEWK[3*w+1]); s2 = 9'(NEWK[3*w+2]);
    return {5'b10101, s2, s1, s0};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic lookup(input int k, output int got, output bit v);
    @(negedge clk);
    req_valid = 1'b1; req_idx = 5'(k); rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got = int'($signed(rsp_coef));
    v = rsp_valid;
  endtask

  task automatic load_word(input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_data = d;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int got; bit v; bit ok_all; int held;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9: reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    check(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    check(ld_ready == 1'b1, "R9 ld_ready", int'(ld_ready), 1);

    // Table walk: default kernel, R1 values, R4 symmetry, R6 sign extension
    for (int k = 0; k < 32; k++) begin
      lookup(k, got, v);
      check(v && got == exp_default(k), "R1 default coefficient", got, exp_default(k));
      if (k >= 17)
        check(got == exp_default(31-k), "R4 symmetry c[k]=c[31-k]", got, exp_default(31-k));
      if (exp_default(k) < 0)
        check(rsp_coef[15:9] == 7'h7f, "R6 sign extension", int'(rsp_coef[15:9]), 127);
    end

    // R8: partial load leaves the old kernel in place
    for (int w = 0; w < 3; w++) load_word(new_word(w));
    check(ld_ready == 1'b1, "R9 ld_ready during load", int'(ld_ready), 1);
    lookup(4, got, v);
    check(got == exp_default(4), "R8 old kernel mid-load", got, exp_default(4));
    for (int w = 3; w < 5; w++) load_word(new_word(w));

    // R8: lookup accepted on the same edge as the sixth word sees old kernel
    @(negedge clk);
    ld_valid = 1'b1; ld_data = new_word(5);
    req_valid = 1'b1; req_idx = 5'd31; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0; req_valid = 1'b0;
    got = int'($signed(rsp_coef));
    check(rsp_valid && got == exp_default(31), "R8 same-edge lookup old", got, exp_default(31));

    // R2/R3/R4/R5: new kernel placement
    ok_all = 1'b1;
    for (int k = 0; k < 32; k++) begin
      lookup(k, got, v);
      check(v && got == exp_new(k), (k < 17) ? "R3 upward placement" : "R4 mirrored placement",
            got, exp_new(k));
      if (got == NEWK[17]) ok_all = 1'b0;
    end
    check(ok_all, "R5 pad never returned", int'(ok_all), 1);
    lookup(0, got, v);
    check(got == -256, "R2 high bits ignored, slot0 field", got, -256);
    lookup(16, got, v);
    check(got == 120, "R3 index16 is slot1 of sixth word", got, 120);
    lookup(2, got, v);
    check(rsp_coef == 16'hffff, "R6 sign extension of -1", int'(rsp_coef), 65535);

    // R7: back-pressure stall and release
    @(negedge clk);
    req_valid = 1'b1; req_idx = 5'd5; rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_idx = 5'd6;
    check(rsp_valid && int'($signed(rsp_coef)) == exp_new(5), "R7 latency",
          int'($signed(rsp_coef)), exp_new(5));
    held = 0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (rsp_valid && !req_ready && int'($signed(rsp_coef)) == exp_new(5)) held++;
    end
    check(held == 3, "R7 response held under stall", held, 3);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && int'($signed(rsp_coef)) == exp_new(6), "R7 release and next",
          int'($signed(rsp_coef)), exp_new(6));
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 drain", int'(rsp_valid), 0);

    // R1: reset restores default kernel
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    lookup(9, got, v);
    check(got == exp_default(9), "R1 reset restores default", got, exp_default(9));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule